// File: doc/BRIEF.md
# Memory Interface Control Register File

This block is the software-visible control store of a packet-DRAM interface controller. A simple word-addressed bus writes and reads eight 32-bit locations. Those locations hold the transceiver current-control settings, the receive and transmit enables, refresh settings, the DMA latency limit, per-bank shadow status and a set of sticky error flags. Every stored field is also driven straight out to the interface logic. One address produces no stored state. A write to it only fires a one-cycle load strobe towards the transceiver.

The error flags are fed by event strobes from the datapath. An event carries a flag saying whether it was a memory access or a device-register access, two strobes reporting a missing nack or a missing ack, and the access address. The address is compared against a memory-size limit that a configuration input switches between 4 MB and 8 MB. Software reads the flags and clears them all with any write to the error location.

Top module: `memctl_regfile`

## Requirements
- R1: After reset every stored field reads zero, the load strobe is low and the error flags are zero. The exception is the DMA latency field, which resets to 0xF.
- R2: A write to offset 0x04 stores bits [5:0] as the manual current value and bit [6] as the automatic-current enable (1 = automatic). Both are visible on the outputs and in readback from the cycle after the write.
- R3: A write to offset 0x08 with any data makes `curLoadPulse` high for exactly the one cycle after the write edge. No other access raises it.
- R4: Offset 0x0C holds the receive select in bits [3:0] and the transmit select in bits [7:4]. A written receive value other than 0 or 4 leaves the receive field unchanged, and a written transmit value other than 0 or 1 leaves the transmit field unchanged. Each field is judged on its own.
- R5: Offset 0x14 stores a 4-bit DMA latency in bits [3:0].
- R6: A memory event (`evtValid` and `evtIsMem` high) with `nackMiss` sets error bit 0, and one with `ackMiss` sets error bit 1. Set bits stay set until cleared.
- R7: An event with `evtIsMem` low never sets error bits 0 or 1.
- R8: Error bit 2 is set by any event whose address is at or above the limit, which is 2^22 bytes when `bigMem` is 0 and 2^23 bytes when it is 1.
- R9: Any write to offset 0x18 clears all error bits, and offset 0x18 reads the error bits in [2:0]. If a set event arrives in the same cycle as the clearing write, that bit ends up set.
- R10: Read data is zero outside a read access. Bits above each field's width read zero, offset 0x08 reads zero, and data written to those bits has no effect.
- R11: Offset 0x00 stores a 4-bit mode in [3:0], offset 0x10 stores 23 refresh bits in [22:0], and offset 0x1C stores 16 bank-status bits, with the dirty bits in [7:0] and the valid bits in [15:8]. Each is read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [4:2] select the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data (combinational) |
| evtValid | input | 1 | Datapath access event |
| evtIsMem | input | 1 | Event is a memory access (1) or device-register access (0) |
| nackMiss | input | 1 | Expected nack not seen |
| ackMiss | input | 1 | Expected ack not seen |
| evtAddr | input | EVT_ADDR_W | Byte address of the event |
| bigMem | input | 1 | Selects the 8 MB limit (1) or the 4 MB limit (0) |
| modeOut | output | 4 | Mode field |
| curCtlValue | output | 6 | Manual current value |
| curCtlAuto | output | 1 | Automatic current-control enable |
| curLoadPulse | output | 1 | One-cycle current load strobe |
| rxSel | output | 4 | Receive select |
| txSel | output | 4 | Transmit select |
| refreshCfg | output | 23 | Refresh settings |
| dmaLatency | output | 4 | DMA latency limit |
| errFlags | output | 3 | Sticky error flags |
| bankStatus | output | 16 | Bank valid/dirty shadow bits |

## Verification
The hardest situation to produce is a clearing write to the error location that lands in the same cycle as a set event. Another is an error event whose address sits exactly on one of the two limits. The random stimulus draws event addresses from a pool weighted towards the values one byte below and at 4 MB and 8 MB, and it lets bus writes and events fall in the same cycle. Directed steps add a same-cycle clear-and-set, and a device-register event carrying both strobes.

// File: rtl/memctl_regfile_pkg.sv
package memctl_regfile_pkg;
  localparam int REG_SPAN_LOG2 = 5;
  localparam int MODE_W = 4;
  localparam int CCTL_W = 6;
  localparam int SEL_W = 4;
  localparam int REF_W = 23;
  localparam int LAT_W = 4;
  localparam int ERR_W = 3;
  localparam int BANK_W = 16;
  localparam logic [LAT_W-1:0] LAT_RESET = 4'hF;
  localparam logic [SEL_W-1:0] RX_ON = 4'd4;
  localparam logic [SEL_W-1:0] TX_ON = 4'd1;
  localparam int ERR_NACK = 0;
  localparam int ERR_ACK = 1;
  localparam int ERR_RANGE = 2;

  typedef enum logic [2:0] {
    IDX_MODE = 3'd0, IDX_CONFIG = 3'd1, IDX_LOAD = 3'd2, IDX_SELECT = 3'd3,
    IDX_REFRESH = 3'd4, IDX_LATENCY = 3'd5, IDX_ERROR = 3'd6, IDX_BANK = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic wrMode;
    logic wrConfig;
    logic wrLoad;
    logic wrSelect;
    logic wrRefresh;
    logic wrLatency;
    logic wrErrClr;
    logic wrBank;
    logic rdEn;
    regIdx_t rdIdx;
  } regStrobes_t;
endpackage

// File: rtl/memctl_regfile_ctrl.sv
module memctl_regfile_ctrl
  import memctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes
);
  logic    inRange;
  logic    doWrite;
  regIdx_t idx;

  assign inRange = (busAddr >> REG_SPAN_LOG2) == '0;
  assign idx = regIdx_t'(busAddr[REG_SPAN_LOG2-1:2]);
  assign doWrite = busValid && busWrite && inRange;

  always_comb begin
    strobes = '0;
    strobes.rdIdx = idx;
    strobes.rdEn = busValid && !busWrite && inRange;
    if (doWrite) begin
      case (idx)
        IDX_MODE:    strobes.wrMode = 1'b1;
        IDX_CONFIG:  strobes.wrConfig = 1'b1;
        IDX_LOAD:    strobes.wrLoad = 1'b1;
        IDX_SELECT:  strobes.wrSelect = 1'b1;
        IDX_REFRESH: strobes.wrRefresh = 1'b1;
        IDX_LATENCY: strobes.wrLatency = 1'b1;
        IDX_ERROR:   strobes.wrErrClr = 1'b1;
        default:     strobes.wrBank = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/memctl_regfile_dp.sv
module memctl_regfile_dp
  import memctl_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_ADDR_W = 24,
  parameter int SMALL_LIMIT_LOG2 = 22,
  parameter int BIG_LIMIT_LOG2 = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strobes,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  evtValid,
  input  logic                  evtIsMem,
  input  logic                  nackMiss,
  input  logic                  ackMiss,
  input  logic [EVT_ADDR_W-1:0] evtAddr,
  input  logic                  bigMem,
  output logic [MODE_W-1:0]     modeOut,
  output logic [CCTL_W-1:0]     curCtlValue,
  output logic                  curCtlAuto,
  output logic                  curLoadPulse,
  output logic [SEL_W-1:0]      rxSel,
  output logic [SEL_W-1:0]      txSel,
  output logic [REF_W-1:0]      refreshCfg,
  output logic [LAT_W-1:0]      dmaLatency,
  output logic [ERR_W-1:0]      errFlags,
  output logic [BANK_W-1:0]     bankStatus
);
  localparam logic [EVT_ADDR_W:0] SMALL_LIMIT = (EVT_ADDR_W+1)'(1) << SMALL_LIMIT_LOG2;
  localparam logic [EVT_ADDR_W:0] BIG_LIMIT = (EVT_ADDR_W+1)'(1) << BIG_LIMIT_LOG2;

  logic [MODE_W-1:0] modeQ;
  logic [CCTL_W:0]   cfgQ;
  logic [SEL_W-1:0]  rxQ, txQ;
  logic [REF_W-1:0]  refQ;
  logic [LAT_W-1:0]  latQ;
  logic [BANK_W-1:0] bankQ;
  logic              loadQ;
  logic [ERR_W-1:0]  errQ, errSet;
  logic [SEL_W-1:0]  rxNew, txNew;
  logic              overRange;

  assign rxNew = busWdata[SEL_W-1:0];
  assign txNew = busWdata[2*SEL_W-1:SEL_W];
  assign overRange = {1'b0, evtAddr} >= (bigMem ? BIG_LIMIT : SMALL_LIMIT);

  assign errSet[ERR_NACK]  = evtValid && evtIsMem && nackMiss;
  assign errSet[ERR_ACK]   = evtValid && evtIsMem && ackMiss;
  assign errSet[ERR_RANGE] = evtValid && overRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      cfgQ  <= '0;
      rxQ   <= '0;
      txQ   <= '0;
      refQ  <= '0;
      latQ  <= LAT_RESET;
      bankQ <= '0;
      loadQ <= 1'b0;
    end else begin
      loadQ <= strobes.wrLoad;
      if (strobes.wrMode)    modeQ <= busWdata[MODE_W-1:0];
      if (strobes.wrConfig)  cfgQ  <= busWdata[CCTL_W:0];
      if (strobes.wrRefresh) refQ  <= busWdata[REF_W-1:0];
      if (strobes.wrLatency) latQ  <= busWdata[LAT_W-1:0];
      if (strobes.wrBank)    bankQ <= busWdata[BANK_W-1:0];
      if (strobes.wrSelect && (rxNew == '0 || rxNew == RX_ON)) rxQ <= rxNew;
      if (strobes.wrSelect && (txNew == '0 || txNew == TX_ON)) txQ <= txNew;
    end
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errQ[i] <= 1'b0;
      else       errQ[i] <= (errQ[i] && !strobes.wrErrClr) || errSet[i];
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdEn) begin
      case (strobes.rdIdx)
        IDX_MODE:    busRdata = DATA_W'(modeQ);
        IDX_CONFIG:  busRdata = DATA_W'(cfgQ);
        IDX_SELECT:  busRdata = DATA_W'({txQ, rxQ});
        IDX_REFRESH: busRdata = DATA_W'(refQ);
        IDX_LATENCY: busRdata = DATA_W'(latQ);
        IDX_ERROR:   busRdata = DATA_W'(errQ);
        IDX_BANK:    busRdata = DATA_W'(bankQ);
        default:     busRdata = '0;
      endcase
    end
  end

  assign modeOut      = modeQ;
  assign curCtlValue  = cfgQ[CCTL_W-1:0];
  assign curCtlAuto   = cfgQ[CCTL_W];
  assign curLoadPulse = loadQ;
  assign rxSel        = rxQ;
  assign txSel        = txQ;
  assign refreshCfg   = refQ;
  assign dmaLatency   = latQ;
  assign errFlags     = errQ;
  assign bankStatus   = bankQ;
endmodule

// File: rtl/memctl_regfile.sv
module memctl_regfile
  import memctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int EVT_ADDR_W = 24,
  parameter int SMALL_LIMIT_LOG2 = 22,
  parameter int BIG_LIMIT_LOG2 = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  evtValid,
  input  logic                  evtIsMem,
  input  logic                  nackMiss,
  input  logic                  ackMiss,
  input  logic [EVT_ADDR_W-1:0] evtAddr,
  input  logic                  bigMem,
  output logic [3:0]            modeOut,
  output logic [5:0]            curCtlValue,
  output logic                  curCtlAuto,
  output logic                  curLoadPulse,
  output logic [3:0]            rxSel,
  output logic [3:0]            txSel,
  output logic [22:0]           refreshCfg,
  output logic [3:0]            dmaLatency,
  output logic [2:0]            errFlags,
  output logic [15:0]           bankStatus
);
  regStrobes_t strobes;

  memctl_regfile_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobes(strobes)
  );

  memctl_regfile_dp #(
    .DATA_W(DATA_W), .EVT_ADDR_W(EVT_ADDR_W),
    .SMALL_LIMIT_LOG2(SMALL_LIMIT_LOG2), .BIG_LIMIT_LOG2(BIG_LIMIT_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata), .busRdata(busRdata),
    .evtValid(evtValid), .evtIsMem(evtIsMem), .nackMiss(nackMiss), .ackMiss(ackMiss),
    .evtAddr(evtAddr), .bigMem(bigMem), .modeOut(modeOut), .curCtlValue(curCtlValue),
    .curCtlAuto(curCtlAuto), .curLoadPulse(curLoadPulse), .rxSel(rxSel), .txSel(txSel),
    .refreshCfg(refreshCfg), .dmaLatency(dmaLatency), .errFlags(errFlags),
    .bankStatus(bankStatus)
  );
endmodule

// File: rtl/memctl_regfile_checker.sv
module memctl_regfile_checker #(
  parameter int ADDR_W = 5,
  parameter int EVT_ADDR_W = 24,
  parameter int SMALL_LIMIT_LOG2 = 22,
  parameter int BIG_LIMIT_LOG2 = 23
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busValid,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  evtValid,
  input logic                  evtIsMem,
  input logic [EVT_ADDR_W-1:0] evtAddr,
  input logic                  bigMem,
  input logic                  curLoadPulse,
  input logic [3:0]            rxSel,
  input logic [3:0]            txSel,
  input logic [3:0]            dmaLatency,
  input logic [2:0]            errFlags
);
  localparam logic [EVT_ADDR_W:0] SMALL_LIMIT = (EVT_ADDR_W+1)'(1) << SMALL_LIMIT_LOG2;
  localparam logic [EVT_ADDR_W:0] BIG_LIMIT = (EVT_ADDR_W+1)'(1) << BIG_LIMIT_LOG2;

  logic loadWr, errWr, memEvt, rangeEvt;
  assign loadWr = busValid && busWrite && ((busAddr >> 2) == ADDR_W'(2));
  assign errWr  = busValid && busWrite && ((busAddr >> 2) == ADDR_W'(6));
  assign memEvt = evtValid && evtIsMem;
  assign rangeEvt = evtValid && ({1'b0, evtAddr} >= (bigMem ? BIG_LIMIT : SMALL_LIMIT));

  p_latency_reset_r1: assert property (@(posedge clk) $rose(rstN) |-> dmaLatency == 4'hF);
  p_load_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> curLoadPulse);
  p_load_only_on_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !loadWr |=> !curLoadPulse);
  p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxSel == 4'd0 || rxSel == 4'd4) && (txSel == 4'd0 || txSel == 4'd1));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !errWr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));
  p_reg_evt_no_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memEvt |=> ((errFlags[1:0] & ~$past(errFlags[1:0])) == 2'b00));
  p_range_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    rangeEvt |=> errFlags[2]);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errWr && !evtValid) |=> errFlags == 3'b000);
endmodule

bind memctl_regfile memctl_regfile_checker #(
  .ADDR_W(ADDR_W), .EVT_ADDR_W(EVT_ADDR_W),
  .SMALL_LIMIT_LOG2(SMALL_LIMIT_LOG2), .BIG_LIMIT_LOG2(BIG_LIMIT_LOG2)
) u_checker (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .evtValid(evtValid), .evtIsMem(evtIsMem), .evtAddr(evtAddr), .bigMem(bigMem),
  .curLoadPulse(curLoadPulse), .rxSel(rxSel), .txSel(txSel), .dmaLatency(dmaLatency),
  .errFlags(errFlags)
);

// File: tb/memctl_regfile_test.sv
`timescale 1ns/1ps
module memctl_regfile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtValid = 1'b0, evtIsMem = 1'b0, nackMiss = 1'b0, ackMiss = 1'b0, bigMem = 1'b0;
  logic [23:0] evtAddr = '0;
  logic [3:0]  modeOut, rxSel, txSel, dmaLatency;
  logic [5:0]  curCtlValue;
  logic        curCtlAuto, curLoadPulse;
  logic [22:0] refreshCfg;
  logic [2:0]  errFlags;
  logic [15:0] bankStatus;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // model state
  logic [3:0]  mMode = '0;
  logic [6:0]  mCfg = '0;
  logic [3:0]  mRx = '0, mTx = '0, mLat = 4'hF;
  logic [22:0] mRef = '0;
  logic [2:0]  mErr = '0;
  logic [15:0] mBank = '0;
  logic        mPulse = 1'b0;

  always #4 clk = ~clk;

  memctl_regfile uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtValid(evtValid), .evtIsMem(evtIsMem),
    .nackMiss(nackMiss), .ackMiss(ackMiss), .evtAddr(evtAddr), .bigMem(bigMem),
    .modeOut(modeOut), .curCtlValue(curCtlValue), .curCtlAuto(curCtlAuto),
    .curLoadPulse(curLoadPulse), .rxSel(rxSel), .txSel(txSel), .refreshCfg(refreshCfg),
    .dmaLatency(dmaLatency), .errFlags(errFlags), .bankStatus(bankStatus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {28'd0, mMode};
      3'd1: return {25'd0, mCfg};
      3'd3: return {24'd0, mTx, mRx};
      3'd4: return {9'd0, mRef};
      3'd5: return {28'd0, mLat};
      3'd6: return {29'd0, mErr};
      3'd7: return {16'd0, mBank};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string readTag(input logic [4:0] a);
    case (a[4:2])
      3'd1: return "R2 config readback";
      3'd2: return "R10 load offset reads zero";
      3'd3: return "R4 select readback";
      3'd5: return "R5 latency readback";
      3'd6: return "R9 error readback";
      default: return "R11 readback";
    endcase
  endfunction

  task automatic checkOutputs(input string errTag);
    chk("R11 mode out", {28'd0, modeOut}, {28'd0, mMode});
    chk("R2 config out", {25'd0, curCtlAuto, curCtlValue}, {25'd0, mCfg});
    chk("R3 load pulse", {31'd0, curLoadPulse}, {31'd0, mPulse});
    chk("R4 select out", {24'd0, txSel, rxSel}, {24'd0, mTx, mRx});
    chk("R11 refresh out", {9'd0, refreshCfg}, {9'd0, mRef});
    chk("R5 latency out", {28'd0, dmaLatency}, {28'd0, mLat});
    chk("R11 bank out", {16'd0, bankStatus}, {16'd0, mBank});
    chk(errTag, {29'd0, errFlags}, {29'd0, mErr});
  endtask

  task automatic step(input bit v, input bit w, input logic [4:0] a, input logic [31:0] d,
                      input bit ev, input bit mem, input bit nk, input bit ak,
                      input logic [23:0] ea, input bit big);
    logic [2:0] setV;
    bit clr;
    bit over;
    string eTag;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d;
    evtValid = ev; evtIsMem = mem; nackMiss = nk; ackMiss = ak; evtAddr = ea; bigMem = big;
    #1;
    if (v && !w) chk(readTag(a), busRdata, expRead(a));
    else chk("R10 idle read zero", busRdata, 32'd0);
    over = big ? (ea >= 24'h800000) : (ea >= 24'h400000);
    setV = {ev && over, ev && mem && ak, ev && mem && nk};
    clr = v && w && (a[4:2] == 3'd6);
    if (clr) eTag = "R9 error clear/set";
    else if (ev && !mem && (nk || ak)) eTag = "R7 register event";
    else if (ev && over) eTag = "R8 overrange";
    else eTag = "R6 sticky errors";
    @(posedge clk);
    #1;
    mPulse = v && w && (a[4:2] == 3'd2);
    if (v && w) begin
      case (a[4:2])
        3'd0: mMode = d[3:0];
        3'd1: mCfg = d[6:0];
        3'd3: begin
          if (d[3:0] == 4'd0 || d[3:0] == 4'd4) mRx = d[3:0];
          if (d[7:4] == 4'd0 || d[7:4] == 4'd1) mTx = d[7:4];
        end
        3'd4: mRef = d[22:0];
        3'd5: mLat = d[3:0];
        3'd7: mBank = d[15:0];
        default: ;
      endcase
    end
    mErr = (clr ? 3'b000 : mErr) | setV;
    checkOutputs(eTag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0, 0, 0, 24'd0, 0);
  endtask

  task automatic rd(input logic [4:0] a);
    step(1, 0, a, 32'd0, 0, 0, 0, 0, 24'd0, 0);
  endtask

  task automatic evt(input bit mem, input bit nk, input bit ak, input logic [23:0] ea, input bit big);
    step(0, 0, 5'd0, 32'd0, 1, mem, nk, ak, ea, big);
  endtask

  function automatic logic [23:0] pickAddr();
    case ($urandom_range(0, 5))
      0: return 24'h3FFFFF;
      1: return 24'h400000;
      2: return 24'h7FFFFF;
      3: return 24'h800000;
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 reset latency", {28'd0, dmaLatency}, 32'hF);
    chk("R1 reset errors", {29'd0, errFlags}, 32'd0);
    chk("R1 reset load pulse", {31'd0, curLoadPulse}, 32'd0);
    chk("R1 reset select", {24'd0, txSel, rxSel}, 32'd0);
    rd(5'h14);
    rd(5'h04);

    // R2 config fields, R10 reserved bits ignored
    wr(5'h04, 32'hFFFF_FF90);
    rd(5'h04);
    wr(5'h04, 32'h0000_0010);
    // R3 load pulse for any data, then low
    wr(5'h08, 32'h0);
    rd(5'h08);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h08, 32'h1234_5678);
    rd(5'h00);
    // R4 legal and illegal selects
    wr(5'h0C, 32'h0000_0014);
    wr(5'h0C, 32'h0000_0025);
    wr(5'h0C, 32'h0000_0004);
    wr(5'h0C, 32'h0000_0013);
    rd(5'h0C);
    // R5 latency, R11 mode/refresh/bank
    wr(5'h14, 32'hFFFF_FFF3);
    wr(5'h00, 32'hFFFF_FFFE);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hABCD_5AA5);
    rd(5'h10);
    rd(5'h1C);
    // R6, R7 error events
    evt(0, 1, 1, 24'h000100, 0);
    evt(1, 1, 0, 24'h000100, 0);
    evt(1, 0, 1, 24'h000100, 0);
    evt(0, 0, 0, 24'h000100, 0);
    rd(5'h18);
    wr(5'h18, 32'h0);
    // R8 boundaries
    evt(0, 0, 0, 24'h3FFFFF, 0);
    evt(0, 0, 0, 24'h400000, 0);
    wr(5'h18, 32'hFFFF_FFFF);
    evt(0, 0, 0, 24'h7FFFFF, 1);
    evt(0, 0, 0, 24'h800000, 1);
    // R9 clear and set in the same cycle
    step(1, 1, 5'h18, 32'h0, 1, 1, 1, 0, 24'h000010, 0);
    rd(5'h18);

    for (int i = 0; i < 3000; i++) begin
      bit v;
      bit w;
      v = ($urandom_range(0, 3) != 0);
      w = $urandom_range(0, 1) == 1;
      step(v, w, 5'($urandom_range(0, 7) * 4 + $urandom_range(0, 3)),
           ($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'($urandom_range(0, 31) << 2),
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           pickAddr(), $urandom_range(0, 1) == 1);
    end

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule